// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, looking only at its 48-bit destination address. The receive path presents the address and the CRC-32 already computed over its six bytes, with a one-cycle strobe. The filter compares the address against four exact-match entries. Entry 0 holds the station's own address and entries 1 to 3 hold multicast addresses. For group addresses it can also consult a 64-bit hash table. It then returns an accept flag and a set of classification bits that the receive engine copies into the descriptor status word.

Software loads the entries, the hash words and two control bits through a simple 16-bit write port. Each control bit sets a mode: one turns on the hash lookup and the other accepts every frame. The address enters at `da_addr[7:0]`, which is the first byte on the wire, so bit 0 is the group bit. An entry's low word covers bytes 0 and 1, its middle word bytes 2 and 3, and its high word bytes 4 and 5.

Top module: `rx_dafilter`

## Requirements
- R1: While reset is held and right after it is released, `flt_done`, `flt_accept` and `flt_status` are 0. All entries, hash words and control bits are cleared, so a unicast address is rejected.
- R2: A write with `cfg_wr_en` loads word w (0 low, 1 middle, 2 high) of entry n at byte address 8*n + 2*w. It loads hash word j at 0x20 + 2*j and the control bits at 0x28, where bit 5 is promiscuous and bit 8 is hash enable. A write to any other address changes nothing.
- R3: An address equal to a non-zero entry is accepted with status bit 2 (0x0004) set and status bits [1:0] holding the entry number. When several entries match, the lowest entry number is reported. A unicast address that matches nothing, with promiscuous off, is rejected.
- R4: An entry that holds all zeros never matches, even against the all-zero address.
- R5: The all-ones address is always accepted with status bit 5 (0x0020) set and status bit 4 clear.
- R6: Status bit 4 (0x0010) is set exactly when address bit 0 is 1 and the address is not all ones.
- R7: With control bit 8 set and a status-bit-4 address, the hash index is CRC bits [31:26]. Index bits [5:4] select the hash word and bits [3:0] select the bit within it. A set bit accepts the frame and sets status bit 3 (0x0008). With control bit 8 clear, or for a unicast address, status bit 3 stays 0.
- R8: With control bit 5 set, every frame is accepted, and the status bits are still computed as in R3 to R7.
- R9: A strobe sampled at a rising edge updates `flt_accept` and `flt_status` at that edge and raises `flt_done` for exactly one cycle. Without a strobe, both outputs hold their values whatever the address and CRC inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register byte address |
| cfg_wr_data | input | 16 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, first byte in [7:0] |
| da_crc | input | 32 | CRC-32 of the six address bytes |
| flt_done | output | 1 | One-cycle pulse after a decision |
| flt_accept | output | 1 | Frame accepted |
| flt_status | output | 16 | Classification bits for the descriptor |

## Verification
Every result is due one register stage after the strobe. The accept flag, the status word and the done pulse all change at the rising edge that samples `da_valid`. A register write lands at the edge that samples `cfg_wr_en`, so it steers the next strobe. The bench drives inputs on falling edges and reads the outputs at the next falling edge, half a cycle after the updating edge. One cycle later it checks again with the strobe low and different address and CRC inputs, to confirm that the outputs hold and the done pulse has dropped. The hash sweep tries every one-hot table bit against all 64 indices.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W        = 16;
  localparam int DA_W          = 48;
  localparam int WORDS_PER_ENT = DA_W / WORD_W;
  localparam int N_ENT         = 4;
  localparam int ENT_IDX_W     = $clog2(N_ENT);
  localparam int ENT_STRIDE    = 8;
  localparam int HASH_IDX_W    = 6;
  localparam int HASH_BIT_W    = $clog2(WORD_W);
  localparam int HASH_WSEL_W   = HASH_IDX_W - HASH_BIT_W;
  localparam int HASH_WORDS    = 1 << HASH_WSEL_W;
  localparam int REG_AW        = 8;
  localparam int HASH_BASE     = 'h20;
  localparam int CTRL_ADDR     = 'h28;
  localparam int CTRL_PROM_BIT = 5;
  localparam int CTRL_HASH_BIT = 8;
  localparam int ST_BCAST      = 5;
  localparam int ST_MCAST      = 4;
  localparam int ST_HASH       = 3;
  localparam int ST_EXACT      = 2;

  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [31:0] crc);
    return crc[31 -: HASH_IDX_W];
  endfunction

  function automatic logic is_bcast(input logic [DA_W-1:0] a);
    return &a;
  endfunction

  function automatic logic is_group(input logic [DA_W-1:0] a);
    return a[0];
  endfunction
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [REG_AW-1:0]                 wr_addr,
  input  logic [WORD_W-1:0]                 wr_data,
  output logic [N_ENT-1:0][DA_W-1:0]        ent_o,
  output logic [HASH_WORDS-1:0][WORD_W-1:0] hash_o,
  output logic                              promisc_o,
  output logic                              hash_en_o
);
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    for (genvar w = 0; w < WORDS_PER_ENT; w++) begin : g_word
      localparam int WA = ENT_STRIDE * e + 2 * w;
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (wr_en && wr_addr == WA[REG_AW-1:0]) word_q <= wr_data;
      end
      assign ent_o[e][w*WORD_W +: WORD_W] = word_q;
    end
  end

  for (genvar j = 0; j < HASH_WORDS; j++) begin : g_hash
    localparam int HA = HASH_BASE + 2 * j;
    logic [WORD_W-1:0] hword_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hword_q <= '0;
      else if (wr_en && wr_addr == HA[REG_AW-1:0]) hword_q <= wr_data;
    end
    assign hash_o[j] = hword_q;
  end

  localparam int CA = CTRL_ADDR;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_o <= 1'b0;
      hash_en_o <= 1'b0;
    end else if (wr_en && wr_addr == CA[REG_AW-1:0]) begin
      promisc_o <= wr_data[CTRL_PROM_BIT];
      hash_en_o <= wr_data[CTRL_HASH_BIT];
    end
  end
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
  import rxf_pkg::*;
(
  input  logic [DA_W-1:0]            addr,
  input  logic [N_ENT-1:0][DA_W-1:0] ent,
  output logic                       hit,
  output logic [ENT_IDX_W-1:0]       idx
);
  logic [N_ENT-1:0] ent_hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign ent_hit[e] = (|ent[e]) && (ent[e] == addr);
  end

  always_comb begin
    hit = |ent_hit;
    idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (ent_hit[e]) idx = ENT_IDX_W'(e);
    end
  end
endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
  import rxf_pkg::*;
(
  input  logic [31:0]                       crc,
  input  logic [HASH_WORDS-1:0][WORD_W-1:0] table_i,
  output logic                              bit_set
);
  logic [HASH_IDX_W-1:0]  hidx;
  logic [HASH_WSEL_W-1:0] wsel;
  logic [HASH_BIT_W-1:0]  bsel;
  logic                   crc_unused;

  assign hidx       = hash_index(crc);
  assign wsel       = hidx[HASH_IDX_W-1 -: HASH_WSEL_W];
  assign bsel       = hidx[HASH_BIT_W-1:0];
  assign bit_set    = table_i[wsel][bsel];
  assign crc_unused = ^crc[31-HASH_IDX_W:0];
endmodule

// File: rtl/rx_dafilter.sv
module rx_dafilter
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wr_addr,
  input  logic [15:0]       cfg_wr_data,
  input  logic              da_valid,
  input  logic [47:0]       da_addr,
  input  logic [31:0]       da_crc,
  output logic              flt_done,
  output logic              flt_accept,
  output logic [15:0]       flt_status
);
  logic [N_ENT-1:0][DA_W-1:0]        ent_w;
  logic [HASH_WORDS-1:0][WORD_W-1:0] hash_w;
  logic                              promisc_w;
  logic                              hash_en_w;
  logic                              exact_hit_w;
  logic [ENT_IDX_W-1:0]              exact_idx_w;
  logic                              hash_bit_w;
  logic                              bcast_w;
  logic                              mcast_w;
  logic                              hash_hit_w;
  logic                              accept_w;
  logic [15:0]                       status_w;

  rxf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_addr   (cfg_wr_addr),
    .wr_data   (cfg_wr_data),
    .ent_o     (ent_w),
    .hash_o    (hash_w),
    .promisc_o (promisc_w),
    .hash_en_o (hash_en_w)
  );

  rxf_exact_match u_exact (
    .addr (da_addr),
    .ent  (ent_w),
    .hit  (exact_hit_w),
    .idx  (exact_idx_w)
  );

  rxf_hash_lookup u_hash (
    .crc     (da_crc),
    .table_i (hash_w),
    .bit_set (hash_bit_w)
  );

  assign bcast_w    = is_bcast(da_addr);
  assign mcast_w    = is_group(da_addr) && !bcast_w;
  assign hash_hit_w = hash_en_w && mcast_w && hash_bit_w;
  assign accept_w   = exact_hit_w || bcast_w || hash_hit_w || promisc_w;

  always_comb begin
    status_w           = '0;
    status_w[ST_BCAST] = bcast_w;
    status_w[ST_MCAST] = mcast_w;
    status_w[ST_HASH]  = hash_hit_w;
    status_w[ST_EXACT] = exact_hit_w;
    status_w[ENT_IDX_W-1:0] = exact_hit_w ? exact_idx_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_done   <= 1'b0;
      flt_accept <= 1'b0;
      flt_status <= '0;
    end else begin
      flt_done <= da_valid;
      if (da_valid) begin
        flt_accept <= accept_w;
        flt_status <= status_w;
      end
    end
  end

  // Exact-match result must point at an entry that really equals the address
  assert_exact_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exact_hit_w |-> (ent_w[exact_idx_w] == da_addr));

  assert_zero_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exact_hit_w |-> (da_addr != '0));

  assert_bcast_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da_addr)) |=> (flt_accept && flt_status[ST_BCAST] && !flt_status[ST_MCAST]));

  assert_hash_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !hash_en_w) |=> !flt_status[ST_HASH]);

  assert_promisc_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && promisc_w) |=> flt_accept);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(flt_accept) && $stable(flt_status) && !flt_done));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> flt_done);
endmodule

// File: tb/rx_dafilter_bench.sv
`timescale 1ns/1ps
module rx_dafilter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic [31:0] da_crc = '0;
  logic        flt_done;
  logic        flt_accept;
  logic [15:0] flt_status;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [47:0] m_ent [4];
  logic [63:0] m_hash;
  logic        m_prom;
  logic        m_hen;
  logic [17:0] last_exp;

  always #2 clk = ~clk;

  rx_dafilter u_rx_dafilter (
    .clk (clk), .rst_n (rst_n),
    .cfg_wr_en (cfg_wr_en), .cfg_wr_addr (cfg_wr_addr), .cfg_wr_data (cfg_wr_data),
    .da_valid (da_valid), .da_addr (da_addr), .da_crc (da_crc),
    .flt_done (flt_done), .flt_accept (flt_accept), .flt_status (flt_status)
  );

  // Returns {accept, status[15:0]} from the requirements
  function automatic logic [16:0] model(input logic [47:0] a, input logic [31:0] c);
    logic bc, mc, hh, hit, acc;
    logic [1:0] idx;
    logic [15:0] st;
    bc = (a == 48'hFFFF_FFFF_FFFF);
    mc = a[0] && !bc;
    hit = 1'b0;
    idx = 2'd0;
    for (int e = 3; e >= 0; e--) begin
      if (m_ent[e] != 48'd0 && m_ent[e] == a) begin
        hit = 1'b1;
        idx = 2'(e);
      end
    end
    hh = m_hen && mc && m_hash[c[31:26]];
    acc = hit || bc || hh || m_prom;
    st = 16'd0;
    if (bc) st = st | 16'h0020;
    if (mc) st = st | 16'h0010;
    if (hh) st = st | 16'h0008;
    if (hit) st = st | 16'h0004 | {14'd0, idx};
    return {acc, st};
  endfunction

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got done/acc/status=%h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    for (int e = 0; e < 4; e++)
      for (int w = 0; w < 3; w++)
        if (a == 8'(8*e + 2*w)) m_ent[e][w*16 +: 16] = d;
    for (int j = 0; j < 4; j++)
      if (a == 8'(8'h20 + 2*j)) m_hash[j*16 +: 16] = d;
    if (a == 8'h28) begin
      m_prom = d[5];
      m_hen = d[8];
    end
  endtask

  task automatic wr_entry(input int n, input logic [47:0] v);
    for (int w = 0; w < 3; w++) wr(8'(8*n + 2*w), v[w*16 +: 16]);
  endtask

  task automatic wr_table(input logic [63:0] t);
    for (int j = 0; j < 4; j++) wr(8'(8'h20 + 2*j), t[j*16 +: 16]);
  endtask

  task automatic present(input logic [47:0] a, input logic [31:0] c, input string tag);
    logic [17:0] exp;
    exp = {1'b1, model(a, c)};
    @(negedge clk);
    da_valid = 1'b1; da_addr = a; da_crc = c;
    @(negedge clk);
    da_valid = 1'b0;
    check(tag, {flt_done, flt_accept, flt_status}, exp);
    last_exp = exp;
  endtask

  task automatic hold_check(input string tag);
    @(negedge clk);
    da_addr = ~da_addr; da_crc = ~da_crc;
    @(negedge clk);
    check(tag, {flt_done, flt_accept, flt_status}, {1'b0, last_exp[16:0]});
  endtask

  localparam logic [47:0] STN  = 48'h5544_3322_1100;
  localparam logic [47:0] MC1  = 48'h0C0B_0A09_0801;
  localparam logic [47:0] MC2  = 48'h1D1C_1B1A_1901;
  localparam logic [47:0] MC3  = 48'h2E2D_2C2B_2A03;
  localparam logic [47:0] MCX  = 48'h7F7E_7D7C_7B01;
  localparam logic [47:0] UNX  = 48'h5544_3322_1102;
  localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

  initial begin
    for (int e = 0; e < 4; e++) m_ent[e] = '0;
    m_hash = '0; m_prom = 1'b0; m_hen = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {flt_done, flt_accept, flt_status}, 18'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {flt_done, flt_accept, flt_status}, 18'd0);
    present(UNX, 32'h0, "R1 cleared tables reject unicast");
    present(48'd0, 32'h0, "R4 zero address vs empty entries");
    hold_check("R9 hold after reject");

    wr_entry(0, STN); wr_entry(1, MC1); wr_entry(2, MC2); wr_entry(3, MC3);
    present(STN, 32'h1234_5678, "R3 station entry 0");
    hold_check("R9 hold after station hit");
    present(MC1, 32'h0, "R3 exact entry 1");
    present(MC2, 32'h0, "R3 exact entry 2");
    present(MC3, 32'h0, "R3 exact entry 3");
    present(UNX, 32'h0, "R3 unicast miss rejected");
    present(MCX, 32'h0, "R6 group miss flagged multicast");
    present(BCST, 32'hFC00_0000, "R5 broadcast accepted");
    hold_check("R9 hold after broadcast");

    wr_table(64'hFFFF_FFFF_FFFF_FFFF);
    present(MCX, 32'hFC00_0000, "R7 hash disabled no hit");
    wr(8'h28, 16'h0100);
    present(MCX, 32'hFC00_0000, "R7 hash enabled full table");
    present(UNX, 32'hFC00_0000, "R7 unicast never hashes");
    present(BCST, 32'hFC00_0000, "R5 broadcast not hashed");

    for (int b = 0; b < 64; b++) begin
      wr_table(64'd1 << b);
      for (int i = 0; i < 64; i++)
        present(MCX, {6'(i), 26'h155_5555}, "R7 hash sweep");
    end
    wr_table(64'd0);

    wr(8'h28, 16'h0020);
    present(UNX, 32'h0, "R8 promiscuous accepts unicast miss");
    present(MC2, 32'h0, "R8 promiscuous keeps exact status");
    wr(8'h28, 16'h0000);
    present(UNX, 32'h0, "R8 promiscuous cleared");

    wr(8'h06, 16'hABCD);
    wr(8'h2A, 16'h0120);
    wr(8'h3E, 16'hFFFF);
    present(UNX, 32'hFC00_0000, "R2 unmapped writes ignored (control)");
    present(STN, 32'h0, "R2 unmapped writes ignored (entry 0)");
    present(MCX, 32'hFC00_0000, "R2 unmapped writes ignored (hash)");

    wr_entry(3, STN);
    present(STN, 32'h0, "R3 lowest index wins");
    wr_entry(1, 48'd0);
    present(MC1, 32'h0, "R4 cleared entry 1 no longer matches");
    present(48'd0, 32'h0, "R4 zero entry vs zero address");
    wr(8'h10, 16'h1902);
    present(MC2, 32'h0, "R2 low word of entry 2 at 0x10");
    present(48'h1D1C_1B1A_1902, 32'h0, "R2 rewritten entry 2 matches");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule